// File: doc/BRIEF.md
# Octal Buffer Boundary-Scan Instruction and Data Register Unit

This block holds the instruction register of a boundary-scan test port for an eight-bit buffer. It decodes the active instruction into two results. The first is the data register that sits between the serial input and the serial output: the one-bit bypass register, the sixteen-cell boundary register, or a short boundary-control register. The second is the device mode: normal, test, or a modified test mode in which the driven pins float. An external TAP state machine supplies one strobe per controller state, sampled on the rising edge of the test clock. The block performs the capture, shift and update actions of the selected register.

The boundary register has eight input cells on the received pins and eight output cells on the driven pins. In normal mode the driven pins follow the core outputs, and the core inputs follow the received pins. In test mode both come from the update latches of the boundary cells. The serial output is registered on the falling edge of the test clock.

Top module: `scan_octal_tap`

## Requirements
- R1: While `tlr` is high at a rising TCK edge, the active instruction becomes 8'h01 (bypass). After that the device is in normal mode (`test_mode`=0, `hiz_mode`=0, `pin_oe` all ones, `pin_out`=`core_out`, `core_in`=`pin_in`) and the bypass register is selected.
- R2: On Capture-IR the instruction shift register loads 8'b1000_0001. Shift-IR moves TDI into bit 7 and shifts toward bit 0, so TDO presents the bits LSB first: 1,0,0,0,0,0,0,1.
- R3: Bit 7 of the instruction has no effect on the decode. Codes c and c^8'h80 give the same selected register and mode.
- R4: Low seven bits 7'h00 and 7'h03 select the boundary register in test mode. `pin_out[i]` is then output-cell latch i (latch bit 8+i), and `core_in[i]` is input-cell latch i (latch bit i).
- R5: Low seven bits 7'h01, 7'h04, 7'h05, 7'h08 and every code in no other requirement select bypass in normal mode. On Capture-DR with bypass selected, bypass loads 0. Each Shift-DR passes TDI to TDO with one stage of delay.
- R6: 7'h02 selects the boundary register in normal mode. On Capture-DR, cell i loads `pin_in[i]` and cell 8+i loads `core_out[i]`. Cell 0 is nearest TDO, and TDI enters cell 15.
- R7: 7'h06 selects bypass with `hiz_mode`=1, `test_mode`=0 and `pin_oe` all zeros.
- R8: 7'h07, 7'h09 and 7'h0D select bypass in test mode. The pins are then driven from the output-cell latches.
- R9: 7'h0A and 7'h0C select the boundary register in normal mode, and 7'h0B selects it in test mode. 7'h0E and 7'h0F select a 3-cell boundary-control register, in normal and test mode respectively. That register loads zeros on Capture-DR.
- R10: The active instruction changes only on Update-IR (or reset). Capture-IR and Shift-IR leave the mode and the register selection unchanged.
- R11: Boundary update latches change only on Update-DR while the boundary register is selected. Shift-DR alone, or Update-DR with another register selected, leaves them unchanged.
- R12: TDO changes only on the falling TCK edge. It shows bit 0 of the instruction shift register during Capture-IR or Shift-IR, and bit 0 of the selected data register otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | TAP is in Test-Logic-Reset (synchronous) |
| capture_ir | input | 1 | TAP in Capture-IR |
| shift_ir | input | 1 | TAP in Shift-IR |
| update_ir | input | 1 | TAP in Update-IR |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial test data in |
| pin_in | input | 8 | Received data pins |
| core_out | input | 8 | Core logic outputs |
| tdo | output | 1 | Serial test data out, falling-edge registered |
| core_in | output | 8 | Values presented to the core logic inputs |
| pin_out | output | 8 | Values on the driven pins |
| pin_oe | output | 8 | Driven-pin output enables, 1 = driving |
| test_mode | output | 1 | Device is in test mode |
| hiz_mode | output | 1 | Device is in modified test mode, outputs floating |

## Verification
A wrong decode shows up at the ports within one TCK after Update-IR. It can appear as a wrong mode flag or output enable, or as a serial chain of the wrong length, which is measured as the number of shifts before a marker reaches TDO. A corrupted boundary shift or update latch shows up only when it is shifted out, or when a test-mode instruction routes the latches to the pins. So the sequences park known patterns in the latches and then read them back through the pins and TDO. An early serial output is caught by sampling TDO between the rising and falling edges.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int IR_W = 8;
  localparam logic [IR_W-1:0] OP_BYPASS  = 8'h01;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h81;

  typedef enum logic [1:0] {
    DR_BYPASS = 2'd0,
    DR_BOUND  = 2'd1,
    DR_CTRL   = 2'd2
  } dr_sel_e;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_TEST   = 2'd1,
    MD_HIZ    = 2'd2
  } dev_mode_e;

  typedef struct packed {
    dr_sel_e   sel;
    dev_mode_e mode;
  } ir_dec_t;

  // Only the low seven opcode bits take part in the decode.
  function automatic ir_dec_t decode_op(input logic [IR_W-2:0] op);
    ir_dec_t d;
    d.sel  = DR_BYPASS;
    d.mode = MD_NORMAL;
    case (op)
      7'h00, 7'h03, 7'h0B: begin d.sel = DR_BOUND;  d.mode = MD_TEST;   end
      7'h02, 7'h0A, 7'h0C: begin d.sel = DR_BOUND;  d.mode = MD_NORMAL; end
      7'h06:               begin d.sel = DR_BYPASS; d.mode = MD_HIZ;    end
      7'h07, 7'h09, 7'h0D: begin d.sel = DR_BYPASS; d.mode = MD_TEST;   end
      7'h0E:               begin d.sel = DR_CTRL;   d.mode = MD_NORMAL; end
      7'h0F:               begin d.sel = DR_CTRL;   d.mode = MD_TEST;   end
      default:             begin d.sel = DR_BYPASS; d.mode = MD_NORMAL; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/scan_ir.sv
module scan_ir
  import bscan_pkg::*;
(
  input  logic            tck,
  input  logic            tlr,
  input  logic            capture_ir,
  input  logic            shift_ir,
  input  logic            update_ir,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_shift,
  output logic [IR_W-1:0] ir_q
);

  always_ff @(posedge tck) begin
    if (tlr) begin
      ir_shift <= IR_CAPTURE;
    end else if (capture_ir) begin
      ir_shift <= IR_CAPTURE;
    end else if (shift_ir) begin
      ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (tlr) begin
      ir_q <= OP_BYPASS;
    end else if (update_ir) begin
      ir_q <= ir_shift;
    end
  end

endmodule

// File: rtl/scan_decode.sv
module scan_decode
  import bscan_pkg::*;
(
  input  logic [IR_W-1:0] ir_q,
  output dr_sel_e         sel,
  output logic            test_mode,
  output logic            hiz_mode
);

  ir_dec_t dec;
  logic    unused_msb;

  assign unused_msb = ir_q[IR_W-1];
  assign dec        = decode_op(ir_q[IR_W-2:0]);
  assign sel        = dec.sel;
  assign test_mode  = (dec.mode == MD_TEST);
  assign hiz_mode   = (dec.mode == MD_HIZ);

endmodule

// File: rtl/scan_aux_dr.sv
module scan_aux_dr
  import bscan_pkg::*;
#(
  parameter int CTL_W = 3
) (
  input  logic    tck,
  input  logic    tlr,
  input  logic    capture_dr,
  input  logic    shift_dr,
  input  logic    tdi,
  input  dr_sel_e sel,
  output logic    byp_q,
  output logic    ctl_lsb
);

  logic [CTL_W-1:0] ctl_sh;
  logic             byp_en;
  logic             ctl_en;

  assign byp_en = (sel == DR_BYPASS);
  assign ctl_en = (sel == DR_CTRL);

  always_ff @(posedge tck) begin
    if (tlr) begin
      byp_q <= 1'b0;
    end else if (byp_en && capture_dr) begin
      byp_q <= 1'b0;
    end else if (byp_en && shift_dr) begin
      byp_q <= tdi;
    end
  end

  generate
    if (CTL_W == 1) begin : g_ctl1
      always_ff @(posedge tck) begin
        if (tlr || (ctl_en && capture_dr)) begin
          ctl_sh <= '0;
        end else if (ctl_en && shift_dr) begin
          ctl_sh <= tdi;
        end
      end
    end else begin : g_ctln
      always_ff @(posedge tck) begin
        if (tlr || (ctl_en && capture_dr)) begin
          ctl_sh <= '0;
        end else if (ctl_en && shift_dr) begin
          ctl_sh <= {tdi, ctl_sh[CTL_W-1:1]};
        end
      end
    end
  endgenerate

  assign ctl_lsb = ctl_sh[0];

endmodule

// File: rtl/scan_bsr.sv
module scan_bsr #(
  parameter int N = 8
) (
  input  logic         tck,
  input  logic         tlr,
  input  logic         bnd_sel,
  input  logic         capture_dr,
  input  logic         shift_dr,
  input  logic         update_dr,
  input  logic         tdi,
  input  logic         test_mode,
  input  logic         hiz_mode,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] core_out,
  output logic [N-1:0] core_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic [2*N-1:0] bsr_upd,
  output logic         bsr_lsb
);

  localparam int BW = 2 * N;

  logic [BW-1:0] bsr_sh;

  always_ff @(posedge tck) begin
    if (tlr) begin
      bsr_sh <= '0;
    end else if (bnd_sel && capture_dr) begin
      bsr_sh <= {core_out, pin_in};
    end else if (bnd_sel && shift_dr) begin
      bsr_sh <= {tdi, bsr_sh[BW-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (tlr) begin
      bsr_upd <= '0;
    end else if (bnd_sel && update_dr) begin
      bsr_upd <= bsr_sh;
    end
  end

  assign bsr_lsb = bsr_sh[0];

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign core_in[i] = test_mode ? bsr_upd[i]   : pin_in[i];
    assign pin_out[i] = test_mode ? bsr_upd[N+i] : core_out[i];
    assign pin_oe[i]  = ~hiz_mode;
  end

endmodule

// File: rtl/scan_octal_tap.sv
module scan_octal_tap
  import bscan_pkg::*;
#(
  parameter int N     = 8,
  parameter int CTL_W = 3
) (
  input  logic         tck,
  input  logic         tlr,
  input  logic         capture_ir,
  input  logic         shift_ir,
  input  logic         update_ir,
  input  logic         capture_dr,
  input  logic         shift_dr,
  input  logic         update_dr,
  input  logic         tdi,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] core_out,
  output logic         tdo,
  output logic [N-1:0] core_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic         test_mode,
  output logic         hiz_mode
);

  localparam int BW = 2 * N;

  logic [IR_W-1:0] ir_shift;
  logic [IR_W-1:0] ir_q;
  dr_sel_e         sel;
  logic            byp_q;
  logic            ctl_lsb;
  logic            bsr_lsb;
  logic [BW-1:0]   bsr_upd;
  logic            ir_path;
  logic            dr_bit;
  logic            tdo_next;

  scan_ir u_ir (
    .tck        (tck),
    .tlr        (tlr),
    .capture_ir (capture_ir),
    .shift_ir   (shift_ir),
    .update_ir  (update_ir),
    .tdi        (tdi),
    .ir_shift   (ir_shift),
    .ir_q       (ir_q)
  );

  scan_decode u_dec (
    .ir_q      (ir_q),
    .sel       (sel),
    .test_mode (test_mode),
    .hiz_mode  (hiz_mode)
  );

  scan_aux_dr #(.CTL_W(CTL_W)) u_aux (
    .tck        (tck),
    .tlr        (tlr),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .tdi        (tdi),
    .sel        (sel),
    .byp_q      (byp_q),
    .ctl_lsb    (ctl_lsb)
  );

  scan_bsr #(.N(N)) u_bsr (
    .tck        (tck),
    .tlr        (tlr),
    .bnd_sel    (sel == DR_BOUND),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .tdi        (tdi),
    .test_mode  (test_mode),
    .hiz_mode   (hiz_mode),
    .pin_in     (pin_in),
    .core_out   (core_out),
    .core_in    (core_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .bsr_upd    (bsr_upd),
    .bsr_lsb    (bsr_lsb)
  );

  assign ir_path = capture_ir | shift_ir;

  always_comb begin
    case (sel)
      DR_BOUND: dr_bit = bsr_lsb;
      DR_CTRL:  dr_bit = ctl_lsb;
      default:  dr_bit = byp_q;
    endcase
  end

  assign tdo_next = ir_path ? ir_shift[0] : dr_bit;

  always_ff @(negedge tck) begin
    tdo <= tdo_next;
  end

endmodule

// File: rtl/scan_octal_chk.sv
module scan_octal_chk
  import bscan_pkg::*;
#(
  parameter int N = 8
) (
  input logic            tck,
  input logic            tlr,
  input logic            capture_ir,
  input logic            update_ir,
  input logic            capture_dr,
  input logic            update_dr,
  input logic [IR_W-1:0] ir_shift,
  input logic [IR_W-1:0] ir_q,
  input dr_sel_e         sel,
  input logic            byp_q,
  input logic [2*N-1:0]  bsr_upd,
  input logic            hiz_mode,
  input logic [N-1:0]    pin_oe
);

  // R1
  reset_bypass_chk: assert property (@(posedge tck)
    tlr |=> (ir_q == OP_BYPASS));

  // R2
  ir_capture_chk: assert property (@(posedge tck) disable iff (tlr)
    capture_ir |=> (ir_shift == IR_CAPTURE));

  // R5
  bypass_zero_chk: assert property (@(posedge tck) disable iff (tlr)
    (capture_dr && sel == DR_BYPASS) |=> (byp_q == 1'b0));

  // R7
  hiz_float_chk: assert property (@(posedge tck) disable iff (tlr)
    hiz_mode |-> (pin_oe == '0));

  // R10
  ir_hold_chk: assert property (@(posedge tck) disable iff (tlr)
    !update_ir |=> $stable(ir_q));

  // R11
  bsr_hold_chk: assert property (@(posedge tck) disable iff (tlr)
    !(update_dr && sel == DR_BOUND) |=> $stable(bsr_upd));

endmodule

bind scan_octal_tap scan_octal_chk #(.N(N)) u_chk (
  .tck        (tck),
  .tlr        (tlr),
  .capture_ir (capture_ir),
  .update_ir  (update_ir),
  .capture_dr (capture_dr),
  .update_dr  (update_dr),
  .ir_shift   (ir_shift),
  .ir_q       (ir_q),
  .sel        (sel),
  .byp_q      (byp_q),
  .bsr_upd    (bsr_upd),
  .hiz_mode   (hiz_mode),
  .pin_oe     (pin_oe)
);

// File: tb/tb_scan_octal_tap.sv
`timescale 1ns/1ps
module tb_scan_octal_tap;

  logic       tck = 1'b0;
  logic       tlr = 1'b1;
  logic       capture_ir = 0, shift_ir = 0, update_ir = 0;
  logic       capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic       tdi = 0;
  logic [7:0] pin_in = 8'h00, core_out = 8'h00;
  logic       tdo;
  logic [7:0] core_in, pin_out, pin_oe;
  logic       test_mode, hiz_mode;

  int vectors = 0;
  int fails   = 0;
  logic [7:0]  capv;
  logic [15:0] got;

  always #10 tck = ~tck;

  scan_octal_tap dut (
    .tck(tck), .tlr(tlr), .capture_ir(capture_ir), .shift_ir(shift_ir),
    .update_ir(update_ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .pin_in(pin_in), .core_out(core_out),
    .tdo(tdo), .core_in(core_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .test_mode(test_mode), .hiz_mode(hiz_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic cir, input logic sir, input logic uir,
                      input logic cdr, input logic sdr, input logic udr, input logic din);
    capture_ir = cir; shift_ir = sir; update_ir = uir;
    capture_dr = cdr; shift_dr = sdr; update_dr = udr; tdi = din;
    @(posedge tck);
    @(negedge tck);
    #1;
    capture_ir = 0; shift_ir = 0; update_ir = 0;
    capture_dr = 0; shift_dr = 0; update_dr = 0;
  endtask

  task automatic shift_ir_only(input logic [7:0] code);
    step(1,0,0,0,0,0,0);
    capv[0] = tdo;
    for (int k = 0; k < 8; k++) begin
      step(0,1,0,0,0,0,code[k]);
      if (k < 7) capv[k+1] = tdo;
    end
  endtask

  task automatic load_ir(input logic [7:0] code);
    shift_ir_only(code);
    step(0,0,1,0,0,0,0);
  endtask

  // Chain length: capture zeros, then count shifts until a 1 reaches TDO.
  task automatic chain_len(output int len);
    len = 0;
    step(0,0,0,1,0,0,0);
    for (int k = 1; k <= 40; k++) begin
      step(0,0,0,0,1,0,1'b1);
      if (len == 0 && tdo === 1'b1) len = k;
    end
  endtask

  // Capture, then shift 16 bits of pat in; got holds the bits read at TDO.
  task automatic bsr_xfer(input logic [15:0] pat, input logic do_cap);
    if (do_cap) begin
      step(0,0,0,1,0,0,0);
      got[0] = tdo;
    end
    for (int k = 0; k < 16; k++) begin
      step(0,0,0,0,1,0,pat[k]);
      if (k < 15) got[k+1] = tdo;
    end
  endtask

  // Expected decode from the requirements: {length, test, hiz}
  function automatic logic [7:0] exp_dec(input logic [7:0] c);
    logic [6:0] o;
    o = c[6:0];
    if (o == 7'h00 || o == 7'h03 || o == 7'h0B) return {6'd16, 2'b10};
    if (o == 7'h02 || o == 7'h0A || o == 7'h0C) return {6'd16, 2'b00};
    if (o == 7'h06)                             return {6'd1,  2'b01};
    if (o == 7'h07 || o == 7'h09 || o == 7'h0D) return {6'd1,  2'b10};
    if (o == 7'h0E)                             return {6'd3,  2'b00};
    if (o == 7'h0F)                             return {6'd3,  2'b10};
    return {6'd1, 2'b00};
  endfunction

  initial begin : watchdog
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    int len;
    logic [7:0] e;
    logic [7:0] e2;
    @(negedge tck); #1;
    step(0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    tlr = 0;
    pin_in = 8'h3C; core_out = 8'h5A; #1;

    // R1 reset state
    chk("R1 test_mode", test_mode, 0);
    chk("R1 hiz_mode", hiz_mode, 0);
    chk("R1 pin_oe", pin_oe, 8'hFF);
    chk("R1 pin_out", pin_out, 8'h5A);
    chk("R1 core_in", core_in, 8'h3C);
    pin_in = 0; core_out = 0;
    chain_len(len);
    chk("R1 chain", len, 1);

    // Decode sweep over every code: R2 R3 R5 R7 R8 R9
    for (int c = 0; c < 256; c++) begin
      load_ir(c[7:0]);
      e = exp_dec(c[7:0]);
      chk("R2 capture", capv, 8'h81);
      chk("R9 test_mode", test_mode, e[1]);
      chk("R7 hiz_mode", hiz_mode, e[0]);
      chk("R7 pin_oe", pin_oe, e[0] ? 8'h00 : 8'hFF);
      chain_len(len);
      chk("R5 chain", len, e[7:2]);
      e2 = exp_dec(c[7:0] ^ 8'h80);
      chk("R3 bit7", {2'b0, e2[7:2], e2[1:0]}, {2'b0, e[7:2], e[1:0]});
    end

    // R6 sample in normal mode
    load_ir(8'h02);
    pin_in = 8'hA5; core_out = 8'h3C; #1;
    chk("R6 normal pin_out", pin_out, 8'h3C);
    chk("R6 normal core_in", core_in, 8'hA5);
    bsr_xfer(16'hC396, 1);
    chk("R6 captured cells", got, 16'h3CA5);
    chk("R11 pins before update", pin_out, 8'h3C);
    step(0,0,0,0,0,1,0);

    // R4 test mode from latches, bit 7 set and both aliases
    load_ir(8'h00);
    chk("R4 pin_out 00", pin_out, 8'hC3);
    chk("R4 core_in 00", core_in, 8'h96);
    pin_in = 8'h11; core_out = 8'hEE; #1;
    chk("R4 pin_out ignores core", pin_out, 8'hC3);
    chk("R4 core_in ignores pins", core_in, 8'h96);
    load_ir(8'h80);
    chk("R3 pin_out 80", pin_out, 8'hC3);
    load_ir(8'h03);
    chk("R4 pin_out 03", pin_out, 8'hC3);

    // R11 shift without update leaves latches, update applies
    bsr_xfer(16'h5A0F, 0);
    chk("R11 pin_out after shift", pin_out, 8'hC3);
    chk("R11 core_in after shift", core_in, 8'h96);
    step(0,0,0,0,0,1,0);
    chk("R11 pin_out after update", pin_out, 8'h5A);
    chk("R11 core_in after update", core_in, 8'h0F);

    // R8 clamp drives latches; DR update with bypass selected ignored
    load_ir(8'h07);
    chk("R8 clamp pin_out", pin_out, 8'h5A);
    bsr_xfer(16'hFFFF, 1);
    step(0,0,0,0,0,1,0);
    chk("R11 bypass update ignored", pin_out, 8'h5A);
    load_ir(8'h0B);
    chk("R9 0B pin_out", pin_out, 8'h5A);

    // R10 instruction held until Update-IR
    load_ir(8'h06);
    shift_ir_only(8'h00);
    chk("R10 hiz held", hiz_mode, 1);
    chk("R10 test held", test_mode, 0);
    step(0,0,1,0,0,0,0);
    chk("R10 test after update", test_mode, 1);
    chk("R10 hiz after update", hiz_mode, 0);

    // R5 bypass capture zero and one-stage delay; R12 falling-edge TDO
    load_ir(8'h01);
    step(0,0,0,0,1,0,1);
    chk("R5 bypass shift 1", tdo, 1);
    step(0,0,0,1,0,0,0);
    chk("R5 bypass capture 0", tdo, 0);
    step(0,0,0,0,1,0,1);
    chk("R5 delay 1", tdo, 1);
    shift_dr = 1; tdi = 0;
    @(posedge tck); #1;
    chk("R12 tdo held past rising edge", tdo, 1);
    @(negedge tck); #1;
    chk("R12 tdo after falling edge", tdo, 0);
    shift_dr = 0;

    // R1 reset returns to bypass normal
    load_ir(8'h00);
    tlr = 1;
    step(0,0,0,0,0,0,0);
    tlr = 0;
    pin_in = 8'h77; core_out = 8'h22; #1;
    chk("R1 reset test_mode", test_mode, 0);
    chk("R1 reset pin_out", pin_out, 8'h22);
    chk("R1 reset core_in", core_in, 8'h77);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule